// File: doc/BRIEF.md
# IDE Word-to-Byte Data Bridge

This block lets an 8-bit processor bus reach the 16-bit data register of an IDE drive at a single address, two processor accesses per 16-bit word. It is cheap because only the drive's chip selects and the upper eight data lines pass through it. The lower eight drive data lines, the drive register address lines and the read and write strobes connect straight to the processor.

A one-bit phase flag decides how each data-register access is served. In the first phase of a read, the drive is selected. Its low byte reaches the processor directly, and the block latches the high byte from the upper lines. In the second phase the drive is left unselected and the block drives the latched byte onto the processor bus itself. Writes run the same two phases the other way round. The first processor byte is held in the block. On the second write the drive is selected, and the block drives the held byte onto the upper lines while the processor supplies the low byte. As a result, the first byte written lands in the high half of the word, and software or DMA must order its bytes to suit. Accesses to any other drive register pass straight through and do not disturb the phase.

The block samples the strobes with a system clock. The flag flips at the trailing edge of each data-register access, however long the strobe stays active. All bus outputs are combinational functions of the inputs and of the flag, so chip selects and output enables follow the strobes within the same cycle.

Top module: `ide_bridge`

## Requirements
- R1: After reset the phase flag is clear, so the next data-register read selects the drive. With no strobe active, both block output enables are low and both chip selects (active low) are high. A reset in the middle of a pair also returns the flag to the first phase.
- R2: A read of the data register (`cpu_sel`=1, `cpu_addr`=0) with the flag clear drives `ide_cs_n[0]` low and leaves `cpu_doe` low.
- R3: During a first-phase read, the block stores the value on `ide_hi_in`, as sampled at the last clock edge of the access.
- R4: A read of the data register with the flag set leaves both chip selects high, raises `cpu_doe`, and presents the stored byte on `cpu_dout`.
- R5: The flag flips exactly once per data-register access, at the first clock edge after the strobe ends, for any strobe length.
- R6: A write to the data register with the flag clear stores `cpu_din`, leaves both chip selects high and leaves both output enables low.
- R7: A write to the data register with the flag set drives `ide_cs_n[0]` low, raises `ide_hi_oe` and presents the stored byte on `ide_hi_out`. The 16-bit word written is {first byte, second byte}.
- R8: An access inside the window to any other address passes through and leaves the flag unchanged. Address bit 3 picks the chip select: 0 selects `ide_cs_n[0]` and 1 selects `ide_cs_n[1]`. Both output enables stay low.
- R9: With `cpu_sel` low, strobes select nothing, enable no driver and leave the flag unchanged.
- R10: `cpu_doe` and `ide_hi_oe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_sel | input | 1 | Processor select for the drive window |
| cpu_addr | input | 4 | Drive register address; bit 3 picks the chip select |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_din | input | 8 | Processor data bus as seen by the block |
| cpu_dout | output | 8 | Byte the block places on the processor bus |
| cpu_doe | output | 1 | Output enable for `cpu_dout` |
| ide_hi_in | input | 8 | Upper drive data lines as seen by the block |
| ide_hi_out | output | 8 | Byte the block places on the upper drive lines |
| ide_hi_oe | output | 1 | Output enable for `ide_hi_out` |
| ide_cs_n | output | 2 | Drive chip selects, active low |

## Verification
The assertions assume that the read and write strobes are never active together. They also assume that select, address, strobe and incoming data stay steady for the whole of an access, so that an access begins and ends only by its strobe. The stimulus keeps to this. Every access is driven as one call that sets all inputs at a falling clock edge, holds them for a random number of cycles and then drops the strobe, with at least one idle cycle before the next access. Random choices cover direction, window select, address and strobe length. Around them sit directed runs with a long strobe, reset between the two halves of a pair, and writes whose assembled word is compared with the drive model.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_kind_t;

    typedef struct packed {
        logic              phase;
        logic              busy;
        logic [BYTE_W-1:0] hold;
    } seq_state_t;
endpackage

// File: rtl/ide_bridge_decode.sv
module ide_bridge_decode
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_ADDR = 0,
    parameter int NUM_CS    = 2
) (
    input  logic              cpu_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              phase,
    output acc_kind_t         kind,
    output logic [NUM_CS-1:0] cs_n,
    output logic              cpu_oe,
    output logic              hi_oe
);
    localparam int CS_BITS = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic rd_s, wr_s, data_hit, pass_cs;
    logic [CS_BITS-1:0] cs_idx;

    always_comb begin
        rd_s     = cpu_sel & cpu_rd & ~cpu_wr;
        wr_s     = cpu_sel & cpu_wr & ~cpu_rd;
        data_hit = (cpu_addr == ADDR_W'(DATA_ADDR));
        cs_idx   = CS_BITS'(cpu_addr[ADDR_W-1]);

        kind = ACC_NONE;
        if (data_hit && rd_s) kind = ACC_RD;
        if (data_hit && wr_s) kind = ACC_WR;

        // drive is selected on first-phase reads, second-phase writes,
        // and every access to a non-data register
        pass_cs = (rd_s | wr_s) &
                  (~data_hit | (rd_s & ~phase) | (wr_s & phase));

        for (int i = 0; i < NUM_CS; i++) begin
            cs_n[i] = ~(pass_cs && (int'(cs_idx) == i));
        end

        cpu_oe = (kind == ACC_RD) & phase;
        hi_oe  = (kind == ACC_WR) & phase;
    end
endmodule

// File: rtl/ide_bridge_seq.sv
module ide_bridge_seq
    import ide_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_t         kind,
    input  logic [BYTE_W-1:0] ide_hi_in,
    input  logic [BYTE_W-1:0] cpu_din,
    output logic              phase,
    output logic [BYTE_W-1:0] hold
);
    seq_state_t state_d, state_q;
    logic busy_now;

    always_comb begin
        busy_now = (kind != ACC_NONE);
        state_d  = state_q;
        state_d.busy = busy_now;
        if (!state_q.phase && kind == ACC_RD) state_d.hold = ide_hi_in;
        if (!state_q.phase && kind == ACC_WR) state_d.hold = cpu_din;
        // trailing edge of a data-register access
        if (state_q.busy && !busy_now) state_d.phase = ~state_q.phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign phase = state_q.phase;
    assign hold  = state_q.hold;

    assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && !busy_now) |=> (state_q.phase != $past(state_q.phase)))
        else $error("phase did not flip at end of access");

    assert_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q.busy && !busy_now) |=> $stable(state_q.phase))
        else $error("phase moved without an access ending");

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.phase && kind == ACC_RD) |=> (state_q.hold == $past(ide_hi_in)))
        else $error("high byte not captured");

    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.phase |=> $stable(state_q.hold))
        else $error("held byte changed in second phase");
endmodule

// File: rtl/ide_bridge.sv
module ide_bridge
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_din,
    output logic [BYTE_W-1:0] cpu_dout,
    output logic              cpu_doe,
    input  logic [BYTE_W-1:0] ide_hi_in,
    output logic [BYTE_W-1:0] ide_hi_out,
    output logic              ide_hi_oe,
    output logic [1:0]        ide_cs_n
);
    acc_kind_t         kind;
    logic              phase;
    logic [BYTE_W-1:0] hold;

    ide_bridge_decode #(
        .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .NUM_CS(2)
    ) u_decode (
        .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .phase(phase), .kind(kind), .cs_n(ide_cs_n),
        .cpu_oe(cpu_doe), .hi_oe(ide_hi_oe)
    );

    ide_bridge_seq u_seq (
        .clk(clk), .rst_n(rst_n), .kind(kind), .ide_hi_in(ide_hi_in),
        .cpu_din(cpu_din), .phase(phase), .hold(hold)
    );

    assign cpu_dout   = hold;
    assign ide_hi_out = hold;

    assert_cpu_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_doe |-> (&ide_cs_n))
        else $error("drive selected while block drives cpu bus");

    assert_hi_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ide_hi_oe |-> !ide_cs_n[0])
        else $error("upper lines driven without drive selected");

    assert_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sel |-> ((&ide_cs_n) && !cpu_doe && !ide_hi_oe))
        else $error("activity outside window");

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_doe && ide_hi_oe))
        else $error("both drivers enabled");
endmodule

// File: tb/ide_bridge_test.sv
module ide_bridge_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       cpu_sel = 0, cpu_rd = 0, cpu_wr = 0;
    logic [3:0] cpu_addr = 0;
    logic [7:0] cpu_din = 0, ide_hi_in;
    logic [7:0] cpu_dout, ide_hi_out;
    logic       cpu_doe, ide_hi_oe;
    logic [1:0] ide_cs_n;

    int checks = 0, errors = 0;
    bit done = 0;

    // drive model and expected state
    logic [15:0] rd_words [0:15];
    logic [15:0] last_written;
    int          rd_ptr = 0;
    bit          exp_phase = 0;
    logic [7:0]  exp_hold = 0;

    always #2 clk = ~clk;

    assign ide_hi_in = rd_words[rd_ptr][15:8];

    ide_bridge uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_din(cpu_din),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .ide_hi_in(ide_hi_in),
        .ide_hi_out(ide_hi_out), .ide_hi_oe(ide_hi_oe), .ide_cs_n(ide_cs_n)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_cs(bit is_wr, bit sel, logic [3:0] a, bit ph);
        if (!sel) return 2'b11;
        if (a != 4'd0) return a[3] ? 2'b01 : 2'b10;
        if ((!is_wr && !ph) || (is_wr && ph)) return 2'b10;
        return 2'b11;
    endfunction

    function automatic string req_of(bit is_wr, bit sel, logic [3:0] a, bit ph);
        if (!sel) return "R9";
        if (a != 4'd0) return "R8";
        if (!is_wr) return ph ? "R4" : "R2";
        return ph ? "R7" : "R6";
    endfunction

    task automatic access(bit is_wr, bit sel, logic [3:0] a, logic [7:0] wb,
                          int len, output logic [7:0] rb);
        bit data;
        string r;
        @(negedge clk);
        cpu_sel = sel; cpu_addr = a; cpu_din = is_wr ? wb : 8'h00;
        cpu_rd = !is_wr; cpu_wr = is_wr;
        #1;
        data = sel && (a == 4'd0);
        r = req_of(is_wr, sel, a, exp_phase);
        check(r, 32'(ide_cs_n), 32'(exp_cs(is_wr, sel, a, exp_phase)));
        check(r, 32'(cpu_doe), 32'(data && !is_wr && exp_phase));
        check(r, 32'(ide_hi_oe), 32'(data && is_wr && exp_phase));
        if (cpu_doe) check(r, 32'(cpu_dout), 32'(exp_hold));
        if (ide_hi_oe) check(r, 32'(ide_hi_out), 32'(exp_hold));
        rb = cpu_doe ? cpu_dout : (!ide_cs_n[0] ? rd_words[rd_ptr][7:0] : 8'h00);
        if (!ide_cs_n[0] && is_wr && data) last_written = {ide_hi_out, wb};
        repeat (len) @(posedge clk);
        @(negedge clk);
        cpu_sel = 0; cpu_rd = 0; cpu_wr = 0;
        if (data) begin
            if (!exp_phase && !is_wr) begin
                exp_hold = rd_words[rd_ptr][15:8];
                rd_ptr = (rd_ptr + 1) % 16;
            end
            if (!exp_phase && is_wr) exp_hold = wb;
            exp_phase = !exp_phase;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1;
        exp_phase = 0; exp_hold = 0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] lo, hi, dummy;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) rd_words[i] = 16'(i * 16'h1357 + 16'h0A0B);

        do_reset();
        #1;
        // R1: idle outputs after reset
        check("R1", 32'({ide_cs_n, cpu_doe, ide_hi_oe}), 32'({2'b11, 1'b0, 1'b0}));

        // R3 R4: read pair returns low then high byte
        for (int p = 0; p < 3; p++) begin
            logic [15:0] w;
            w = rd_words[rd_ptr];
            access(0, 1, 4'd0, 8'h00, 1 + p, lo);
            access(0, 1, 4'd0, 8'h00, 1, hi);
            check("R3", 32'({hi, lo}), 32'(w));
        end

        // R5: long strobe counts once
        access(0, 1, 4'd0, 8'h00, 25, dummy);
        check("R5", 32'(exp_phase), 32'd1);
        access(0, 1, 4'd0, 8'h00, 1, dummy);

        // R8 R9: other register and outside window leave phase alone
        access(0, 1, 4'd0, 8'h00, 1, dummy);
        access(0, 1, 4'd5, 8'h00, 2, dummy);
        access(1, 1, 4'd9, 8'h33, 2, dummy);
        access(1, 0, 4'd0, 8'h44, 2, dummy);
        access(0, 0, 4'd0, 8'h00, 2, dummy);
        access(0, 1, 4'd0, 8'h00, 1, dummy);

        // R6 R7: write pair assembles {first, second}
        access(1, 1, 4'd0, 8'hC3, 2, dummy);
        access(1, 1, 4'd0, 8'h5A, 3, dummy);
        check("R7", 32'(last_written), 32'h0000C35A);

        // R1: reset between halves of a pair
        access(0, 1, 4'd0, 8'h00, 1, dummy);
        do_reset();
        #1;
        check("R1", 32'(ide_cs_n), 32'h3);
        access(0, 1, 4'd0, 8'h00, 1, dummy);
        check("R1", 32'(exp_phase), 32'd1);
        access(1, 1, 4'd0, 8'h00, 1, dummy);   // back to phase 0

        // random mix; R10 also checked on every access
        for (int n = 0; n < 600; n++) begin
            bit is_wr, sel;
            logic [3:0] a;
            is_wr = $urandom_range(1, 0) == 1;
            sel   = $urandom_range(7, 0) != 0;
            a     = ($urandom_range(3, 0) != 0) ? 4'd0 : 4'($urandom_range(15, 1));
            access(is_wr, sel, a, 8'($urandom), $urandom_range(4, 1), dummy);
            check("R10", 32'(cpu_doe && ide_hi_oe), 32'd0);
            if (is_wr && sel && a == 4'd0 && !exp_phase)
                check("R7", 32'(last_written[7:0]), 32'(cpu_din));
        end

        done = 1;
        finish_run();
    end
endmodule